// File: doc/BRIEF.md
# Pipelined Select-in-Payload Channel Demultiplexer

This block steers each message arriving on a single valid/ready input channel to one of `NUM_OUTS` valid/ready output channels. The destination travels inside the message: the upper bits of the input word are the select and the lower `DATA_W` bits are the data that is delivered. The block has no separate select port.

Routing is done by a tree of small demultiplexer nodes. Each node has `2^BRANCH_LOG2` outputs, and each output is one registered slot that is either empty or full. A node consumes `BRANCH_LOG2` select bits, taking the most significant remaining bits first, and passes the rest of the select down with the data. This keeps the fanout at each level small. A node takes a message only while the slot chosen by that message is empty. A slot that drains at a clock edge is not refilled at that same edge, so a single path moves at most one message every two cycles. This keeps the control logic to one compare per slot.

Each slot runs a two-state machine. In EMPTY, the TAKE transition fires when a message selecting this slot is presented, and the slot moves to FULL. In FULL, the DRAIN transition fires when the downstream ready is high, and the slot moves back to EMPTY. Leaf positions at or above `NUM_OUTS` are tied off. The tree depth is `LEVELS`, the smallest count of levels whose leaves cover `NUM_OUTS`. The select width is `LEVELS*BRANCH_LOG2`.

Top module: `demux_tree`

## Requirements
- R1: After synchronous active-high reset, every `out_valid` bit is low and `in_ready` is high for any select value.
- R2: `in_msg` carries the select in its upper `LEVELS*BRANCH_LOG2` bits and the data in its lower `DATA_W` bits. A message with select j appears only on output j (`out_data[j*DATA_W +: DATA_W]`), with the data unchanged.
- R3: When the path is empty and the outputs are ready, `out_valid[j]` rises at the `LEVELS`-th rising edge, counting the accepting edge as the first.
- R4: `in_ready` is low while the first-level slot chosen by the presented select is full. If an output is stalled, its path holds exactly `LEVELS` messages before the input blocks for that select.
- R5: A slot that drains at an edge is not refilled at that edge. A continuous stream to one output is therefore accepted once every two cycles, and `out_valid` drops for a cycle after each handshake. Streams to two different first-level branches can alternate and be accepted every cycle.
- R6: Messages leave each output in the order they were accepted.
- R7: Every select value from 0 to `NUM_OUTS`-1 is reachable, including when `NUM_OUTS` is not a power of the fan-out. Presenting a select of `NUM_OUTS` or above with `in_valid` high is a protocol error.
- R8: The first level decodes the most significant `BRANCH_LOG2` select bits. A stalled output blocks only the selects that share its first-level branch. Selects in other branches are still accepted and delivered.
- R9: While `out_valid[j]` is high and `out_ready[j]` is low, `out_valid[j]` stays high and `out_data` for j holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input message valid |
| in_ready | output | 1 | Input message accepted when high with in_valid |
| in_msg | input | LEVELS*BRANCH_LOG2+DATA_W | Select in the upper bits, data in the lower bits |
| out_valid | output | NUM_OUTS | Per-output valid |
| out_ready | input | NUM_OUTS | Per-output ready |
| out_data | output | NUM_OUTS*DATA_W | Per-output data, output j in bits j*DATA_W upward |

## Verification
A slot left in the wrong state shows up at the ports within `LEVELS` cycles. A stuck FULL slot keeps `in_ready` low for every select in its subtree. A stuck EMPTY slot or a lost TAKE means the message never reaches its output. A slot refilled at the edge where it drains breaks the alternating valid pattern and changes the count of accepted messages in a stream. A wrong select slice delivers data to the wrong output, or blocks the wrong branch while another output is stalled. The ordered logs of each output show loss, duplication or reordering as soon as the stream drains.

// File: rtl/demux_tree_pkg.sv
package demux_tree_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    // Smallest number of levels whose leaf count covers n outputs.
    function automatic int tree_levels(input int n, input int bl);
        int lv;
        int cap;
        lv  = 0;
        cap = 1;
        while (cap < n) begin
            cap = cap << bl;
            lv  = lv + 1;
        end
        if (lv == 0) lv = 1;
        return lv;
    endfunction

    // Index of the first channel at depth d (depth 0 is the block input).
    function automatic int chan_base(input int d, input int bl);
        int acc;
        acc = 0;
        for (int k = 0; k < d; k++) acc = acc + (1 << (k * bl));
        return acc;
    endfunction

    // Bit offset of the first payload at depth d; payloads shrink by bl per depth.
    function automatic int pay_base(input int d, input int levels, input int bl, input int dw);
        int acc;
        acc = 0;
        for (int k = 0; k < d; k++) acc = acc + (1 << (k * bl)) * (dw + (levels - k) * bl);
        return acc;
    endfunction

endpackage

// File: rtl/demux_node.sv
module demux_node
    import demux_tree_pkg::*;
#(
    parameter int IN_W     = 10,
    parameter int SEL_BITS = 1,
    localparam int FAN     = 1 << SEL_BITS,
    localparam int OUT_W   = IN_W - SEL_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [IN_W-1:0]      in_payload,
    output logic [FAN-1:0]       out_valid,
    input  logic [FAN-1:0]       out_ready,
    output logic [FAN*OUT_W-1:0] out_payload
);

    logic [SEL_BITS-1:0] sel;
    logic [OUT_W-1:0]    fwd;
    slot_state_e         state_q [FAN];
    slot_state_e         state_d [FAN];
    logic [OUT_W-1:0]    slot_q  [FAN];
    logic [FAN-1:0]      take;

    // Most significant select bits are decoded here; the rest travel on.
    always_comb begin
        sel = in_payload[IN_W-1 -: SEL_BITS];
        fwd = in_payload[OUT_W-1:0];
    end

    // Next-state logic of every slot: TAKE (EMPTY->FULL), DRAIN (FULL->EMPTY).
    always_comb begin
        for (int k = 0; k < FAN; k++) begin
            state_d[k] = state_q[k];
            take[k]    = 1'b0;
            unique case (state_q[k])
                SLOT_EMPTY: begin
                    if (in_valid && (sel == SEL_BITS'(k))) begin
                        state_d[k] = SLOT_FULL;
                        take[k]    = 1'b1;
                    end
                end
                SLOT_FULL: begin
                    if (out_ready[k]) state_d[k] = SLOT_EMPTY;
                end
                default: state_d[k] = SLOT_EMPTY;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < FAN; k++) state_q[k] <= SLOT_EMPTY;
        end else begin
            for (int k = 0; k < FAN; k++) state_q[k] <= state_d[k];
        end
    end

    // Data slots load only on TAKE; no reset needed, valid gates them.
    always_ff @(posedge clk) begin
        for (int k = 0; k < FAN; k++) begin
            if (take[k]) slot_q[k] <= fwd;
        end
    end

    // Outputs from state.
    always_comb begin
        in_ready = (state_q[sel] == SLOT_EMPTY);
        for (int k = 0; k < FAN; k++) begin
            out_valid[k]                     = (state_q[k] == SLOT_FULL);
            out_payload[k*OUT_W +: OUT_W]    = slot_q[k];
        end
    end

endmodule

// File: rtl/demux_tree.sv
module demux_tree
    import demux_tree_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int NUM_OUTS    = 16,
    parameter int BRANCH_LOG2 = 2,
    localparam int FAN        = 1 << BRANCH_LOG2,
    localparam int LEVELS     = tree_levels(NUM_OUTS, BRANCH_LOG2),
    localparam int SEL_W      = LEVELS * BRANCH_LOG2,
    localparam int MSG_W      = SEL_W + DATA_W,
    localparam int LEAVES     = 1 << SEL_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [MSG_W-1:0]           in_msg,
    output logic [NUM_OUTS-1:0]        out_valid,
    input  logic [NUM_OUTS-1:0]        out_ready,
    output logic [NUM_OUTS*DATA_W-1:0] out_data
);

    localparam int NCH  = chan_base(LEVELS + 1, BRANCH_LOG2);
    localparam int NPAY = pay_base(LEVELS + 1, LEVELS, BRANCH_LOG2, DATA_W);
    localparam int LC   = chan_base(LEVELS, BRANCH_LOG2);
    localparam int LP   = pay_base(LEVELS, LEVELS, BRANCH_LOG2, DATA_W);

    // All channels of all depths, flattened; depth 0 is the block input.
    logic [NCH-1:0]  ch_valid;
    logic [NCH-1:0]  ch_ready;
    logic [NPAY-1:0] ch_pay;

    assign ch_valid[0]        = in_valid;
    assign ch_pay[MSG_W-1:0]  = in_msg;
    assign in_ready           = ch_ready[0];

    for (genvar d = 0; d < LEVELS; d++) begin : g_lvl
        localparam int NODES = 1 << (d * BRANCH_LOG2);
        localparam int IN_W  = DATA_W + (LEVELS - d) * BRANCH_LOG2;
        localparam int OUT_W = IN_W - BRANCH_LOG2;
        localparam int CI    = chan_base(d, BRANCH_LOG2);
        localparam int CO    = chan_base(d + 1, BRANCH_LOG2);
        localparam int PI    = pay_base(d, LEVELS, BRANCH_LOG2, DATA_W);
        localparam int PO    = pay_base(d + 1, LEVELS, BRANCH_LOG2, DATA_W);
        for (genvar n = 0; n < NODES; n++) begin : g_node
            demux_node #(
                .IN_W     (IN_W),
                .SEL_BITS (BRANCH_LOG2)
            ) u_node (
                .clk         (clk),
                .rst         (rst),
                .in_valid    (ch_valid[CI + n]),
                .in_ready    (ch_ready[CI + n]),
                .in_payload  (ch_pay[PI + n*IN_W +: IN_W]),
                .out_valid   (ch_valid[CO + n*FAN +: FAN]),
                .out_ready   (ch_ready[CO + n*FAN +: FAN]),
                .out_payload (ch_pay[PO + n*FAN*OUT_W +: FAN*OUT_W])
            );
        end
    end

    // Leaves map to ports; leaves past NUM_OUTS are tied off.
    for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
        if (j < NUM_OUTS) begin : g_used
            assign out_valid[j]                  = ch_valid[LC + j];
            assign out_data[j*DATA_W +: DATA_W]  = ch_pay[LP + j*DATA_W +: DATA_W];
            assign ch_ready[LC + j]              = out_ready[j];
        end else begin : g_spare
            assign ch_ready[LC + j] = 1'b1;
        end
    end

endmodule

// File: rtl/demux_tree_chk.sv
module demux_tree_chk
    import demux_tree_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int NUM_OUTS    = 16,
    parameter int BRANCH_LOG2 = 2,
    localparam int LEVELS     = tree_levels(NUM_OUTS, BRANCH_LOG2),
    localparam int SEL_W      = LEVELS * BRANCH_LOG2,
    localparam int MSG_W      = SEL_W + DATA_W
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic [MSG_W-1:0]           in_msg,
    input logic [NUM_OUTS-1:0]        out_valid,
    input logic [NUM_OUTS-1:0]        out_ready,
    input logic [NUM_OUTS*DATA_W-1:0] out_data
);

    logic [SEL_W-1:0] sel;
    assign sel = in_msg[MSG_W-1 -: SEL_W];

    a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_valid == '0));

    a_r7_sel_in_range: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (int'(sel) < NUM_OUTS));

    a_r5_input_gap: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> ($stable(sel) -> !in_ready));

    for (genvar j = 0; j < NUM_OUTS; j++) begin : g_out
        a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
            (out_valid[j] && !out_ready[j]) |=>
                (out_valid[j] && $stable(out_data[j*DATA_W +: DATA_W])));

        a_r5_no_refill: assert property (@(posedge clk) disable iff (rst)
            (out_valid[j] && out_ready[j]) |=> !out_valid[j]);
    end

endmodule

bind demux_tree demux_tree_chk #(
    .DATA_W      (DATA_W),
    .NUM_OUTS    (NUM_OUTS),
    .BRANCH_LOG2 (BRANCH_LOG2)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_msg    (in_msg),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/sim_demux_tree.sv
`timescale 1ns/1ps
module sim_demux_tree;

    localparam int DW  = 8;
    localparam int NO  = 6;
    localparam int BL  = 1;
    localparam int LV  = 3;
    localparam int SW  = 3;
    localparam int MW  = SW + DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [MW-1:0] in_msg = '0;
    logic [NO-1:0] out_valid;
    logic [NO-1:0] out_ready = '1;
    logic [NO*DW-1:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int       hs_cnt [NO];
    logic [DW-1:0] hs_log [NO][64];

    always #5 clk = ~clk;

    demux_tree #(.DATA_W(DW), .NUM_OUTS(NO), .BRANCH_LOG2(BL)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_msg(in_msg), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    initial for (int j = 0; j < NO; j++) hs_cnt[j] = 0;

    // Handshake log per output, sampled well after the drive point.
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            for (int j = 0; j < NO; j++) begin
                if (out_valid[j] && out_ready[j]) begin
                    if (hs_cnt[j] < 64) hs_log[j][hs_cnt[j]] = out_data[j*DW +: DW];
                    hs_cnt[j] = hs_cnt[j] + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] odat(input int j);
        return out_data[j*DW +: DW];
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);
        for (int s = 0; s < NO; s++) begin
            in_msg = {SW'(s), 8'h00};
            #1;
            check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        end
    endtask

    // One message per output; checks routing and pipeline latency.
    task automatic t_route();
        out_ready = '1;
        for (int j = 0; j < NO; j++) begin
            int base;
            base = hs_cnt[j];
            @(negedge clk);
            in_valid = 1'b1;
            in_msg   = {SW'(j), 8'hA0 + 8'(j)};
            #1;
            check(in_ready == 1'b1, "R2", "in_ready on empty path", int'(in_ready), 1);
            for (int e = 1; e <= LV; e++) begin
                @(posedge clk);
                @(negedge clk);
                in_valid = 1'b0;
                #1;
                if (e < LV)
                    check(out_valid == '0, "R3", "early out_valid", int'(out_valid), 0);
                else begin
                    check(out_valid == NO'(1 << j), "R2", "only selected output valid",
                          int'(out_valid), 1 << j);
                    check(odat(j) == 8'hA0 + 8'(j), "R2", "delivered data",
                          int'(odat(j)), 'hA0 + j);
                end
            end
            repeat (2) @(negedge clk);
            #1;
            check(hs_cnt[j] - base == 1, "R7", "one handshake on output", hs_cnt[j] - base, 1);
        end
    endtask

    // Continuous stream to one output, then alternating between two branches.
    task automatic t_stream();
        int acc;
        int base5;
        int base1;
        int base4;
        bit ok;
        out_ready = '1;
        acc   = 0;
        base5 = hs_cnt[5];
        @(negedge clk);
        in_valid = 1'b1;
        for (int c = 0; c < 20; c++) begin
            bit a;
            in_msg = {3'd5, 8'(acc)};
            #1;
            a = in_ready;
            @(posedge clk);
            @(negedge clk);
            if (a) acc++;
        end
        in_valid = 1'b0;
        check(acc == 10, "R5", "accepts in 20 cycles, one output", acc, 10);
        repeat (8) @(negedge clk);
        #1;
        check(hs_cnt[5] - base5 == 10, "R6", "handshakes on output 5", hs_cnt[5] - base5, 10);
        ok = 1'b1;
        for (int k = 0; k < 10; k++) if (hs_log[5][base5 + k] != 8'(k)) ok = 1'b0;
        check(ok, "R6", "order on output 5", int'(ok), 1);

        acc   = 0;
        base1 = hs_cnt[1];
        base4 = hs_cnt[4];
        @(negedge clk);
        in_valid = 1'b1;
        for (int c = 0; c < 20; c++) begin
            bit a;
            in_msg = {((acc % 2) != 0) ? 3'd4 : 3'd1, 8'(acc)};
            #1;
            a = in_ready;
            @(posedge clk);
            @(negedge clk);
            if (a) acc++;
        end
        in_valid = 1'b0;
        check(acc == 20, "R5", "accepts in 20 cycles, two branches", acc, 20);
        repeat (8) @(negedge clk);
        #1;
        ok = (hs_cnt[1] - base1 == 10) && (hs_cnt[4] - base4 == 10);
        for (int k = 0; k < 10; k++) begin
            if (hs_log[1][base1 + k] != 8'(2*k))     ok = 1'b0;
            if (hs_log[4][base4 + k] != 8'(2*k + 1)) ok = 1'b0;
        end
        check(ok, "R6", "order on outputs 1 and 4", int'(ok), 1);
    endtask

    // Send one message, waiting for in_ready up to a limit.
    task automatic send(input int s, input logic [DW-1:0] d, output bit ok);
        ok = 1'b0;
        @(negedge clk);
        in_valid = 1'b1;
        in_msg   = {SW'(s), d};
        for (int w = 0; w < 12; w++) begin
            #1;
            if (in_ready) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (ok) @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_stall();
        bit ok;
        bit held;
        bit blocked;
        int base0;
        int base5;
        out_ready    = '1;
        out_ready[0] = 1'b0;
        base0 = hs_cnt[0];
        send(0, 8'h11, ok); check(ok, "R4", "first stalled-path message", int'(ok), 1);
        send(0, 8'h22, ok); check(ok, "R4", "second stalled-path message", int'(ok), 1);
        send(0, 8'h33, ok); check(ok, "R4", "third stalled-path message", int'(ok), 1);
        @(negedge clk);
        in_valid = 1'b1;
        in_msg   = {3'd0, 8'h44};
        blocked  = 1'b1;
        held     = 1'b1;
        for (int c = 0; c < 8; c++) begin
            #1;
            if (in_ready) blocked = 1'b0;
            if (!out_valid[0] || odat(0) != 8'h11) held = 1'b0;
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(blocked, "R4", "input blocked after LEVELS messages", int'(!blocked), 0);
        check(held, "R9", "stalled output holds first message", int'(odat(0)), 'h11);
        in_msg = {3'd2, 8'h00};
        #1;
        check(in_ready == 1'b0, "R8", "select 2 shares blocked branch", int'(in_ready), 0);
        in_msg = {3'd4, 8'h00};
        #1;
        check(in_ready == 1'b1, "R8", "select 4 in free branch", int'(in_ready), 1);
        base5 = hs_cnt[5];
        send(5, 8'h55, ok);
        repeat (LV + 2) @(negedge clk);
        #1;
        check(ok && (hs_cnt[5] - base5 == 1) && (hs_log[5][base5] == 8'h55), "R8",
              "delivery to other branch during stall", hs_cnt[5] - base5, 1);
        out_ready[0] = 1'b1;
        repeat (10) @(negedge clk);
        #1;
        ok = (hs_cnt[0] - base0 == 3) && (hs_log[0][base0] == 8'h11) &&
             (hs_log[0][base0 + 1] == 8'h22) && (hs_log[0][base0 + 2] == 8'h33);
        check(ok, "R6", "stalled output drains in order", hs_cnt[0] - base0, 3);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_route();
        t_stream();
        t_stall();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end

endmodule